// File: doc/BRIEF.md
# Shift-Keying Profile Selector

This block turns the state of four external profile pins into the index of the profile word that a single synthesis channel should use for direct shift-keying modulation. It also reports the register address that holds that profile. The number of modulation levels (2, 4, 8 or 16) sets how many pins form the index. A pin configuration field picks which pins are used when fewer than four are needed.

The same block sources the output amplitude ramp request. Depending on a 2-bit ramp mode, the request comes from nowhere (held low), from profile pin P3, or from a dedicated ramp data pin. Taking P3 for ramping leaves only three pins for profile selection. Using the ramp data pin needs the serial port in its single-bit mode. Any combination of ramp mode, level and port mode that breaks these rules raises an error flag and freezes the outputs.

All pins pass through a multi-stage synchronizer before decoding. The configuration fields are expected to be quasi-static register outputs in the block's clock domain.

Top module: `prof_mod_sel`

## Requirements
- R1: While reset is asserted and after its release with no pin activity, prof_idx is 0, reg_addr is PROF0_ADDR (default 0x04), ramp_req is 0 and cfg_err is 0.
- R2: With ramp_mode = 2'b10 the only legal level is mod_level = 2'b10 (8 levels), and ramp_req follows profile pin P3 (prof_pins[3]).
- R3: With ramp_mode = 2'b11 the configuration is legal only when ser_1bit = 1 and mod_level is not 2'b10. In that case ramp_req follows ramp_dpin: 1 requests ramp-up and 0 requests ramp-down.
- R4: For 2 levels (mod_level = 2'b00), prof_idx = {3'b000, P[pin_cfg[1:0]]}, where P0 is prof_pins[0] and P3 is prof_pins[3].
- R5: For 4 levels (mod_level = 2'b01), prof_idx = {2'b00, P0, P1} when pin_cfg[2] = 0 and {2'b00, P2, P3} when pin_cfg[2] = 1. Example: pin_cfg 3'b011 with P0 = P1 = 1 gives profile 3.
- R6: For 8 levels (mod_level = 2'b10), prof_idx = {1'b0, P0, P1, P2}.
- R7: For 16 levels (mod_level = 2'b11), prof_idx = {P0, P1, P2, P3}. Example: P0..P3 = 1,1,0,1 gives profile 13.
- R8: reg_addr equals PROF0_ADDR for profile 0 and PROFN_BASE + n (default 0x09 + n) for profile n from 1 to 15. So profile 3 maps to 0x0C and profile 13 maps to 0x16.
- R9: When the configuration is illegal, cfg_err is 1 one clock after the fields take that value, and prof_idx and ramp_req hold their previous values. Both resume when a legal configuration is written.
- R10: A pin change reaches prof_idx and ramp_req exactly SYNC_STAGES+1 rising edges after it is applied (3 by default).
- R11: With ramp_mode = 2'b00 or 2'b01 and a legal configuration, ramp_req is 0. All level settings are legal in these modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ramp_mode | input | 2 | Ramp source: 00/01 none, 10 pin P3, 11 ramp data pin |
| mod_level | input | 2 | 00: 2, 01: 4, 10: 8, 11: 16 levels |
| pin_cfg | input | 3 | Pin choice for 2-level and 4-level operation |
| ser_1bit | input | 1 | Serial port is in single-bit mode |
| prof_pins | input | 4 | Asynchronous profile pins, bit n is Pn |
| ramp_dpin | input | 1 | Asynchronous ramp data pin |
| prof_idx | output | 4 | Selected profile number |
| reg_addr | output | ADDR_W | Address of the selected profile register |
| ramp_req | output | 1 | Ramp request, 1 = up, 0 = down |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
The collision of interest is a pin change arriving in the same cycle that the configuration becomes illegal. The bench provokes it by changing the profile pins and the mode fields on the same clock edge. Because the error path is one stage long and the pin path is SYNC_STAGES+1 stages long, the freeze must catch the new pins before they reach the output. The bench then expects the old profile and the error flag together, and expects the new profile once a legal configuration is restored. Random trials also mix ramp pin and profile pin edges in the same cycle, and both outputs are compared against a bench model of the rules above.

// File: rtl/prof_mod_pkg.sv
package prof_mod_pkg;

   typedef enum logic [1:0] {
      LVL_2  = 2'b00,
      LVL_4  = 2'b01,
      LVL_8  = 2'b10,
      LVL_16 = 2'b11
   } level_e;

   typedef enum logic [1:0] {
      RMP_OFF0 = 2'b00,
      RMP_OFF1 = 2'b01,
      RMP_PIN3 = 2'b10,
      RMP_DPIN = 2'b11
   } ramp_src_e;

   localparam int unsigned NUM_PINS = 4;
   localparam int unsigned IDX_W    = 4;

   typedef struct packed {
      logic [IDX_W-1:0] idx;
      logic             ramp;
      logic             legal;
   } sel_t;

endpackage

// File: rtl/prof_pin_sync.sv
module prof_pin_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("prof_pin_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("prof_pin_sync: WIDTH must be at least 1");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], d_async[b]};
      end
      assign q_sync[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/prof_sel_decode.sv
module prof_sel_decode
   import prof_mod_pkg::*;
(
   input  logic [1:0]          ramp_mode,
   input  logic [1:0]          mod_level,
   input  logic [2:0]          pin_cfg,
   input  logic                ser_1bit,
   input  logic [NUM_PINS-1:0] pins,
   input  logic                dpin,
   output sel_t                sel
);
   level_e    lvl;
   ramp_src_e src;

   assign lvl = level_e'(mod_level);
   assign src = ramp_src_e'(ramp_mode);

   always_comb begin
      sel = '0;
      unique case (lvl)
         LVL_2:  sel.idx = {3'b000, pins[pin_cfg[1:0]]};
         LVL_4:  sel.idx = pin_cfg[2] ? {2'b00, pins[2], pins[3]}
                                      : {2'b00, pins[0], pins[1]};
         LVL_8:  sel.idx = {1'b0, pins[0], pins[1], pins[2]};
         LVL_16: sel.idx = {pins[0], pins[1], pins[2], pins[3]};
         default: sel.idx = '0;
      endcase

      unique case (src)
         RMP_PIN3: begin
            sel.legal = (lvl == LVL_8);
            sel.ramp  = pins[3];
         end
         RMP_DPIN: begin
            sel.legal = ser_1bit && (lvl != LVL_8);
            sel.ramp  = dpin;
         end
         default: begin
            sel.legal = 1'b1;
            sel.ramp  = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/prof_addr_map.sv
module prof_addr_map #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned PROF0_ADDR = 8'h04,
   parameter int unsigned PROFN_BASE = 8'h09
) (
   input  logic [3:0]        idx,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [ADDR_W-1:0] A0   = ADDR_W'(PROF0_ADDR);
   localparam logic [ADDR_W-1:0] BASE = ADDR_W'(PROFN_BASE);

   if (PROFN_BASE + 15 >= (1 << ADDR_W)) begin : g_bad_map
      $error("prof_addr_map: profile 15 address does not fit ADDR_W");
   end

   always_comb begin
      if (idx == 4'd0) addr = A0;
      else             addr = BASE + ADDR_W'(idx);
   end
endmodule

// File: rtl/prof_mod_sel.sv
module prof_mod_sel
   import prof_mod_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned PROF0_ADDR  = 8'h04,
   parameter int unsigned PROFN_BASE  = 8'h09
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        ramp_mode,
   input  logic [1:0]        mod_level,
   input  logic [2:0]        pin_cfg,
   input  logic              ser_1bit,
   input  logic [3:0]        prof_pins,
   input  logic              ramp_dpin,
   output logic [3:0]        prof_idx,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              ramp_req,
   output logic              cfg_err
);
   localparam int unsigned SYNC_W = NUM_PINS + 1;

   logic [SYNC_W-1:0] pins_s;
   sel_t              sel;

   prof_pin_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({ramp_dpin, prof_pins}),
      .q_sync  (pins_s)
   );

   prof_sel_decode u_dec (
      .ramp_mode (ramp_mode),
      .mod_level (mod_level),
      .pin_cfg   (pin_cfg),
      .ser_1bit  (ser_1bit),
      .pins      (pins_s[NUM_PINS-1:0]),
      .dpin      (pins_s[NUM_PINS]),
      .sel       (sel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prof_idx <= '0;
         ramp_req <= 1'b0;
         cfg_err  <= 1'b0;
      end else begin
         cfg_err <= !sel.legal;
         if (sel.legal) begin
            prof_idx <= sel.idx;
            ramp_req <= sel.ramp;
         end
      end
   end

   prof_addr_map #(
      .ADDR_W     (ADDR_W),
      .PROF0_ADDR (PROF0_ADDR),
      .PROFN_BASE (PROFN_BASE)
   ) u_map (
      .idx  (prof_idx),
      .addr (reg_addr)
   );
endmodule

// File: rtl/prof_mod_sel_chk.sv
module prof_mod_sel_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] ramp_mode,
   input logic [1:0] mod_level,
   input logic       ser_1bit,
   input logic [3:0] prof_idx,
   input logic       ramp_req,
   input logic       cfg_err
);
   a_r9_err_freezes_idx: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> ($stable(prof_idx) && $stable(ramp_req)));

   a_r2_pin3_needs_8lvl: assert property (@(posedge clk) disable iff (!rst_n)
      (ramp_mode == 2'b10 && mod_level != 2'b10) |=> cfg_err);

   a_r3_dpin_needs_1bit: assert property (@(posedge clk) disable iff (!rst_n)
      (ramp_mode == 2'b11 && !ser_1bit) |=> cfg_err);

   a_r4_two_level_range: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_err && $past(mod_level) == 2'b00) |-> (prof_idx[3:1] == 3'b000));

   a_r6_eight_level_range: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_err && $past(mod_level) == 2'b10) |-> !prof_idx[3]);

   a_r11_no_ramp_source: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_err && !$past(ramp_mode[1])) |-> !ramp_req);
endmodule

bind prof_mod_sel prof_mod_sel_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ramp_mode (ramp_mode),
   .mod_level (mod_level),
   .ser_1bit  (ser_1bit),
   .prof_idx  (prof_idx),
   .ramp_req  (ramp_req),
   .cfg_err   (cfg_err)
);

// File: tb/prof_mod_sel_test.sv
module prof_mod_sel_test;
   localparam int CLK_PERIOD = 10;
   localparam int SYNC_N     = 2;
   localparam int SETTLE     = SYNC_N + 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ramp_mode = 2'b00;
   logic [1:0] mod_level = 2'b00;
   logic [2:0] pin_cfg = 3'b000;
   logic       ser_1bit = 1'b0;
   logic [3:0] prof_pins = 4'h0;
   logic       ramp_dpin = 1'b0;
   logic [3:0] prof_idx;
   logic [7:0] reg_addr;
   logic       ramp_req;
   logic       cfg_err;

   int n_chk = 0;
   int n_err = 0;
   int exp_idx = 0;
   int exp_ramp = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prof_mod_sel #(.SYNC_STAGES(SYNC_N)) uut (
      .clk(clk), .rst_n(rst_n), .ramp_mode(ramp_mode), .mod_level(mod_level),
      .pin_cfg(pin_cfg), .ser_1bit(ser_1bit), .prof_pins(prof_pins),
      .ramp_dpin(ramp_dpin), .prof_idx(prof_idx), .reg_addr(reg_addr),
      .ramp_req(ramp_req), .cfg_err(cfg_err)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic bit is_legal();
      if (ramp_mode == 2'b10) return mod_level == 2'b10;
      if (ramp_mode == 2'b11) return ser_1bit && mod_level != 2'b10;
      return 1'b1;
   endfunction

   function automatic int model_idx();
      logic p0, p1, p2, p3;
      {p3, p2, p1, p0} = prof_pins;
      case (mod_level)
         2'b00: return int'(prof_pins[pin_cfg[1:0]]);
         2'b01: return pin_cfg[2] ? int'({p2, p3}) : int'({p0, p1});
         2'b10: return int'({p0, p1, p2});
         default: return int'({p0, p1, p2, p3});
      endcase
   endfunction

   function automatic int model_ramp();
      if (ramp_mode == 2'b10) return int'(prof_pins[3]);
      if (ramp_mode == 2'b11) return int'(ramp_dpin);
      return 0;
   endfunction

   function automatic int model_addr(input int idx);
      return (idx == 0) ? 4 : 9 + idx;
   endfunction

   task automatic settle_and_check(input string tag);
      repeat (SETTLE) @(posedge clk);
      @(negedge clk);
      if (is_legal()) begin
         exp_idx  = model_idx();
         exp_ramp = model_ramp();
      end
      check({tag, " R9 err"}, int'(cfg_err), int'(!is_legal()));
      check({tag, " idx"}, int'(prof_idx), exp_idx);
      check({tag, " R8 addr"}, int'(reg_addr), model_addr(exp_idx));
      check({tag, " ramp"}, int'(ramp_req), exp_ramp);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      check("R1 idx in reset", int'(prof_idx), 0);
      check("R1 addr in reset", int'(reg_addr), 4);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R1 idx", int'(prof_idx), 0);
      check("R1 ramp", int'(ramp_req), 0);
      check("R1 err", int'(cfg_err), 0);

      // R5 example: cfg 011, P0:P1 = 11 -> profile 3 at 0x0C
      mod_level = 2'b01; pin_cfg = 3'b011; prof_pins = 4'b0011;
      settle_and_check("R5 example");
      check("R5 idx 3", int'(prof_idx), 3);
      check("R8 addr 0x0C", int'(reg_addr), 8'h0C);

      // R7 example: P0..P3 = 1,1,0,1 -> profile 13 at 0x16
      mod_level = 2'b11; prof_pins = 4'b1011;
      settle_and_check("R7 example");
      check("R7 idx 13", int'(prof_idx), 13);
      check("R8 addr 0x16", int'(reg_addr), 8'h16);

      // R10 latency: change pins at negedge, sample after each edge
      prof_pins = 4'b0100;
      for (int k = 1; k <= SYNC_N + 1; k++) begin
         @(posedge clk);
         @(negedge clk);
         check("R10 latency", int'(prof_idx), (k <= SYNC_N) ? 13 : 2);
      end
      exp_idx = 2;

      // R2: P3 drives ramp in 8-level
      ramp_mode = 2'b10; mod_level = 2'b10; prof_pins = 4'b1001;
      settle_and_check("R2 pin3");
      check("R2 ramp up", int'(ramp_req), 1);
      check("R6 idx", int'(prof_idx), 4);

      // R3: data pin ramp, then missing 1-bit port
      ramp_mode = 2'b11; mod_level = 2'b00; ser_1bit = 1'b1;
      pin_cfg = 3'b010; ramp_dpin = 1'b1; prof_pins = 4'b0100;
      settle_and_check("R3 dpin up");
      check("R3 ramp up", int'(ramp_req), 1);
      check("R4 idx", int'(prof_idx), 1);
      ramp_dpin = 1'b0;
      settle_and_check("R3 dpin down");
      check("R3 ramp down", int'(ramp_req), 0);
      ser_1bit = 1'b0;
      settle_and_check("R3 port mode");
      check("R3 err", int'(cfg_err), 1);

      // R9 collision: pins change in the same cycle the config turns illegal
      ser_1bit = 1'b1; mod_level = 2'b11; prof_pins = 4'b0001;
      settle_and_check("R9 setup");
      @(negedge clk);
      prof_pins = 4'b1110; mod_level = 2'b10;
      settle_and_check("R9 collision");
      check("R9 held idx", int'(prof_idx), 8);
      mod_level = 2'b11;
      settle_and_check("R9 recover");
      check("R9 new idx", int'(prof_idx), 7);

      // R11: no ramp source
      ramp_mode = 2'b01; prof_pins = 4'b1111; ramp_dpin = 1'b1;
      settle_and_check("R11 off");
      check("R11 ramp low", int'(ramp_req), 0);

      for (int t = 0; t < 400; t++) begin
         @(negedge clk);
         ramp_mode = 2'($urandom_range(3));
         mod_level = 2'($urandom_range(3));
         pin_cfg   = 3'($urandom_range(7));
         ser_1bit  = ($urandom_range(3) != 0);
         prof_pins = 4'($urandom_range(15));
         ramp_dpin = 1'($urandom_range(1));
         settle_and_check("R4 R5 R6 R7 random");
      end

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule